// File: doc/BRIEF.md
# Power-Save Mode Arbiter for a Synchronous Buck Controller

This block chooses, one switching cycle at a time, how the low-side switch of a synchronous buck converter behaves. It can run the converter in forced continuous conduction, where the low-side switch conducts for the whole off period. It can also run it in a pulse-skipping power-save mode, where the low-side switch opens once the inductor current reaches zero. The zero-crossing comparator (phase node against power ground), the end-of-cycle strobe and the low-side gate state all arrive as digital inputs. The on-time one-shot and the gate drivers sit outside the block.

The converter moves into power-save mode only after a full run of consecutive switching cycles, each of which showed a zero crossing while the low-side switch was on. It leaves power-save mode on the first cycle without one. While in power-save mode the block tells the on-time one-shot to stretch its pulse by half. The enable pin has three states and is decoded upstream into two inputs. Driven high, the converter is on and power-save mode is allowed. Left floating, the converter is on but held in continuous conduction. Driven low, the converter is off.

Top module: `psave_mode_ctrl`

## Requirements
- R1: After reset, psave_active_o is 0, ls_off_req_o is 0 and ton_scale_o is 2'b00.
- R2: A switching cycle counts as crossed only if zero_cross_i and ls_on_i were both 1 on the same clock somewhere in that cycle. The strobe clock is included. A cycle ends on a clock where cycle_end_i is 1. A crossing flag seen while ls_on_i is 0 does not count.
- R3: Power-save mode turns on at the clock edge that samples the strobe of the ENTRY_CYCLES-th consecutive crossed cycle (default 8). After one fewer crossed cycle it is still off.
- R4: In power-save mode, the first cycle that is not crossed ends the mode at the clock edge that samples its strobe.
- R5: A cycle that is not crossed resets the run. Entry after that needs a fresh full run of ENTRY_CYCLES crossed cycles.
- R6: The run count saturates at ENTRY_CYCLES. Power-save mode holds through any longer run, and a single cycle that is not crossed still ends it at once.
- R7: While psave_allow_i is 0 (floating pin), the run and the mode are cleared at every clock and power-save mode is never entered.
- R8: While enable_i is 0, the run and the mode are cleared synchronously. A partial run made before that does not survive.
- R9: ls_off_req_o equals 1 on exactly those clocks where power-save mode is active and ls_on_i and zero_cross_i are both 1. It responds in the same clock with no register in the path, and it is 0 in continuous conduction.
- R10: ton_scale_o is 2'b01 (1.5x on-time) while power-save mode is active and 2'b00 (nominal) otherwise. Codes 2'b10 and 2'b11 are never driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Converter enabled (pin not low) |
| psave_allow_i | input | 1 | Power-save permitted (pin driven high) |
| cycle_end_i | input | 1 | One-clock strobe closing each switching cycle |
| ls_on_i | input | 1 | Low-side switch currently on |
| zero_cross_i | input | 1 | Phase node has reached power ground |
| psave_active_o | output | 1 | Power-save mode in effect |
| ls_off_req_o | output | 1 | Request to open the low-side switch now |
| ton_scale_o | output | 2 | On-time scale code: 00 nominal, 01 1.5x |

## Verification
An off-by-one in the run counter changes the strobe on which psave_active_o rises. That shows up on the seventh or eighth crossed cycle of a run. A counter that wraps instead of saturating drops the mode somewhere in a long crossed run. A per-cycle crossing flag that is not cleared at the strobe keeps the mode alive through a cycle that is not crossed, and this is visible at the clock edge that samples that strobe. A missed clear on enable or on the allow input shows as an entry that comes too early once conditions return, so runs of one short of the entry length are placed right after each clear.

// File: rtl/psave_pkg.sv
`timescale 1ns/1ps
package psave_pkg;
  typedef enum logic [1:0] {
    TON_NOMINAL = 2'b00,
    TON_STRETCH = 2'b01
  } ton_scale_e;

  typedef enum logic {
    MODE_CCM   = 1'b0,
    MODE_PSAVE = 1'b1
  } mode_e;
endpackage

// File: rtl/zc_cycle_latch.sv
`timescale 1ns/1ps
module zc_cycle_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cycle_end_i,
  input  logic ls_on_i,
  input  logic zero_cross_i,
  output logic crossed_o
);
  logic seen_q;
  logic hit;

  assign hit       = ls_on_i & zero_cross_i;
  assign crossed_o = seen_q | hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 seen_q <= 1'b0;
    else if (clr_i | cycle_end_i) seen_q <= 1'b0;
    else if (hit)                seen_q <= 1'b1;
  end
endmodule

// File: rtl/zc_run_counter.sv
`timescale 1ns/1ps
module zc_run_counter #(
  parameter int unsigned ENTRY_CYCLES = 8,
  localparam int unsigned CNT_W = $clog2(ENTRY_CYCLES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             crossed_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(ENTRY_CYCLES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ENTRY_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)           cnt_d = '0;
    else if (step_i) begin
      if (!crossed_i)    cnt_d = '0;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  // this strobe completes the run
  assign last_o = (cnt_q >= CNT_LAST);
endmodule

// File: rtl/psave_mode_fsm.sv
`timescale 1ns/1ps
module psave_mode_fsm
  import psave_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic step_i,
  input  logic crossed_i,
  input  logic run_last_i,
  output logic active_o
);
  mode_e mode_q, mode_d;

  always_comb begin
    mode_d = mode_q;
    if (clr_i) mode_d = MODE_CCM;
    else if (step_i) begin
      if (!crossed_i)     mode_d = MODE_CCM;
      else if (run_last_i) mode_d = MODE_PSAVE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_CCM;
    else         mode_q <= mode_d;
  end

  assign active_o = (mode_q == MODE_PSAVE);
endmodule

// File: rtl/psave_mode_ctrl.sv
`timescale 1ns/1ps
module psave_mode_ctrl
  import psave_pkg::*;
#(
  parameter int unsigned ENTRY_CYCLES = 8,
  localparam int unsigned CNT_W = $clog2(ENTRY_CYCLES + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       enable_i,
  input  logic       psave_allow_i,
  input  logic       cycle_end_i,
  input  logic       ls_on_i,
  input  logic       zero_cross_i,
  output logic       psave_active_o,
  output logic       ls_off_req_o,
  output logic [1:0] ton_scale_o
);
  logic             clr;
  logic             cyc_crossed;
  logic [CNT_W-1:0] run_cnt;
  logic             run_last;
  ton_scale_e       scale;

  // floating pin (allow low) forces CCM exactly like disable
  assign clr = ~enable_i | ~psave_allow_i;

  zc_cycle_latch u_latch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clr_i        (clr),
    .cycle_end_i  (cycle_end_i),
    .ls_on_i      (ls_on_i),
    .zero_cross_i (zero_cross_i),
    .crossed_o    (cyc_crossed)
  );

  zc_run_counter #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (clr),
    .step_i    (cycle_end_i),
    .crossed_i (cyc_crossed),
    .cnt_o     (run_cnt),
    .last_o    (run_last)
  );

  psave_mode_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (clr),
    .step_i     (cycle_end_i),
    .crossed_i  (cyc_crossed),
    .run_last_i (run_last),
    .active_o   (psave_active_o)
  );

  assign scale        = psave_active_o ? TON_STRETCH : TON_NOMINAL;
  assign ton_scale_o  = scale;
  assign ls_off_req_o = psave_active_o & ls_on_i & zero_cross_i;
endmodule

// File: rtl/psave_mode_ctrl_chk.sv
`timescale 1ns/1ps
module psave_mode_ctrl_chk #(
  parameter int unsigned ENTRY_CYCLES = 8,
  localparam int unsigned CNT_W = $clog2(ENTRY_CYCLES + 1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             psave_allow_i,
  input logic             cycle_end_i,
  input logic             psave_active_o,
  input logic             ls_off_req_o,
  input logic [1:0]       ton_scale_o,
  input logic             cyc_crossed,
  input logic [CNT_W-1:0] run_cnt
);
  AST_EXIT_ON_MISS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cycle_end_i && !cyc_crossed) |=> !psave_active_o); // R4

  AST_ENTRY_ON_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(psave_active_o) |-> $past(cycle_end_i)); // R3

  AST_CNT_SATURATES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_cnt <= CNT_W'(ENTRY_CYCLES)); // R6

  AST_CCM_WHEN_FLOAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psave_allow_i |=> !psave_active_o); // R7

  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> (!psave_active_o && run_cnt == '0)); // R8

  AST_LSOFF_IN_PSAVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ls_off_req_o |-> psave_active_o); // R9

  AST_SCALE_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ton_scale_o[1] == 1'b0); // R10

  AST_MODE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cycle_end_i && enable_i && psave_allow_i) |=> $stable(psave_active_o)); // R2
endmodule

bind psave_mode_ctrl psave_mode_ctrl_chk #(.ENTRY_CYCLES(ENTRY_CYCLES)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .enable_i       (enable_i),
  .psave_allow_i  (psave_allow_i),
  .cycle_end_i    (cycle_end_i),
  .psave_active_o (psave_active_o),
  .ls_off_req_o   (ls_off_req_o),
  .ton_scale_o    (ton_scale_o),
  .cyc_crossed    (cyc_crossed),
  .run_cnt        (run_cnt)
);

// File: tb/psave_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module psave_mode_ctrl_tb_top;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0, allow = 1'b0, cend = 1'b0, ls_on = 1'b0, zc = 1'b0;
  logic       active, lsoff;
  logic [1:0] scale;
  int         checks = 0;
  int         errors = 0;

  always #2.5 clk = ~clk;

  psave_mode_ctrl #(.ENTRY_CYCLES(N)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(en), .psave_allow_i(allow),
    .cycle_end_i(cend), .ls_on_i(ls_on), .zero_cross_i(zc),
    .psave_active_o(active), .ls_off_req_o(lsoff), .ton_scale_o(scale));

  task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one switching cycle; state sampled after the strobe edge
  task automatic sw_cycle(input logic ls, input logic z);
    @(negedge clk); ls_on = ls; zc = z; cend = 1'b0;
    @(negedge clk); ls_on = 1'b0; zc = 1'b0; cend = 1'b1;
    @(negedge clk); cend = 1'b0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) sw_cycle(1'b1, 1'b1);
  endtask

  task automatic t_reset;
    check("R1 active", {1'b0, active}, 2'b00);
    check("R1 lsoff", {1'b0, lsoff}, 2'b00);
    check("R1 scale", scale, 2'b00);
  endtask

  task automatic t_entry;
    run(N - 1);
    check("R3 not after N-1", {1'b0, active}, 2'b00);
    check("R10 nominal", scale, 2'b00);
    run(1);
    check("R3 entry after N", {1'b0, active}, 2'b01);
    check("R10 stretch", scale, 2'b01);
  endtask

  task automatic t_lsoff;
    @(negedge clk); ls_on = 1'b1; zc = 1'b1; #1;
    check("R9 req in psave", {1'b0, lsoff}, 2'b01);
    zc = 1'b0; #1;
    check("R9 no req without zc", {1'b0, lsoff}, 2'b00);
    @(negedge clk); ls_on = 1'b0;
  endtask

  task automatic t_exit;
    sw_cycle(1'b1, 1'b0);
    check("R4 exit on miss", {1'b0, active}, 2'b00);
    check("R10 back nominal", scale, 2'b00);
    @(negedge clk); ls_on = 1'b1; zc = 1'b1; #1;
    check("R9 no req in CCM", {1'b0, lsoff}, 2'b00);
    @(negedge clk); ls_on = 1'b0; zc = 1'b0;
    sw_cycle(1'b0, 1'b0);
  endtask

  task automatic t_broken_run;
    run(5); sw_cycle(1'b1, 1'b0); run(N - 1);
    check("R5 broken run no entry", {1'b0, active}, 2'b00);
    run(1);
    check("R5 fresh run enters", {1'b0, active}, 2'b01);
    sw_cycle(1'b1, 1'b0);
  endtask

  task automatic t_ls_qualify;
    for (int i = 0; i < N + 2; i++) sw_cycle(1'b0, 1'b1);
    check("R2 zc with ls off ignored", {1'b0, active}, 2'b00);
    // crossing during strobe clock counts
    for (int i = 0; i < N; i++) begin
      @(negedge clk); cend = 1'b1; ls_on = 1'b1; zc = 1'b1;
      @(negedge clk); cend = 1'b0; ls_on = 1'b0; zc = 1'b0;
    end
    check("R2 strobe-clock crossing", {1'b0, active}, 2'b01);
    sw_cycle(1'b1, 1'b0);
  endtask

  task automatic t_saturate;
    run(N + 20);
    check("R6 holds on long run", {1'b0, active}, 2'b01);
    sw_cycle(1'b1, 1'b0);
    check("R6 exit after saturation", {1'b0, active}, 2'b00);
    run(N - 1);
    check("R6 counter reset from max", {1'b0, active}, 2'b00);
    sw_cycle(1'b1, 1'b0);
  endtask

  task automatic t_float;
    allow = 1'b0;
    run(N + 3);
    check("R7 no entry floating", {1'b0, active}, 2'b00);
    allow = 1'b1;
    run(N);
    check("R7 entry when allowed", {1'b0, active}, 2'b01);
    @(negedge clk); allow = 1'b0;
    @(negedge clk);
    check("R7 drop forces CCM", {1'b0, active}, 2'b00);
    allow = 1'b1;
    run(N - 1);
    check("R7 run cleared", {1'b0, active}, 2'b00);
    sw_cycle(1'b1, 1'b0);
  endtask

  task automatic t_disable;
    run(N - 1);
    @(negedge clk); en = 1'b0;
    @(negedge clk); en = 1'b1;
    run(1);
    check("R8 partial run cleared", {1'b0, active}, 2'b00);
    run(N - 1);
    check("R8 full run enters", {1'b0, active}, 2'b01);
    @(negedge clk); en = 1'b0;
    @(negedge clk);
    check("R8 disable clears mode", {1'b0, active}, 2'b00);
    check("R10 nominal when off", scale, 2'b00);
    en = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1; en = 1'b1; allow = 1'b1;
    @(negedge clk);
    t_entry();
    t_lsoff();
    t_exit();
    t_broken_run();
    t_ls_qualify();
    t_saturate();
    t_float();
    t_disable();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule